// File: doc/BRIEF.md
# Per-Range DAC Calibration Register Bank

This block holds the digital input and calibration state for the level-setting DACs of a four-channel force/measure front end. Each channel has five DACs: force, comparator low, comparator high, clamp low and clamp high. Each DAC keeps a raw input code X1, a gain coefficient M and an offset coefficient C, with one set for each force range. When X1 is written, the block computes a corrected code X2 for that set and stores it. Writing M or C only stores the coefficient. The stored X2 does not change until X1 of that set is written again.

A write port carries a channel mask, a DAC select, a range select, a 2-bit mode and a data word. A separate readback port uses the same decode and returns the addressed register combinationally. Each channel's active force range and force mode are inputs. For the force and comparator DACs, the active range picks which stored X2 is driven out. For the clamp DACs, the force mode picks the set. A single offset DAC serves all channels. It has only an input register, which is driven out directly.

No state machine is used. All control lives in the address decode and in a fixed two-stage arithmetic pipeline per channel.

Top module: `calbank_top`

## Requirements
- R1: The DAC select encodes 0 = force, 1 = comparator low, 2 = comparator high, 3 = clamp low, 4 = clamp high and 5 = shared offset. For DACs 0 to 2, the range select picks one of six sets: 0 = ±5 µA, 1 = ±20 µA, 2 = ±200 µA, 3 = ±2 mA, 4 = external, 5 = voltage.
- R2: Clamp DACs 3 and 4 hold two sets each. Range 0 selects the set shared by all current ranges and range 5 selects the voltage set. Ranges 1 to 4 are reserved for them.
- R3: The mode selects the register: 01 = M, 10 = C, 11 = X1; 00 is reserved. The readback port returns the register named by the same encoding.
- R4: X2 = floor(X1·(M+1)/65536) + C − 32768, saturated to 0..65535.
- R5: Writing M or C never changes any X2 output. Only an X1 write to a set recomputes that set's X2, using the M and C held at the time of the X1 write.
- R6: For an X1 write sampled in cycle k, the new X2 appears and x2_done_o is high in cycle k+2, for exactly one cycle per write.
- R7: The offset DAC is written with DAC select 5 and mode 11 when any mask bit is set. The range field is ignored. ofs_code_o shows the stored word, and other modes are reserved for it.
- R8: The force and comparator outputs of a channel show the X2 of the set given by that channel's active range, where values 5 to 7 select the voltage set. The clamp outputs show the current-range set when the channel's force mode is 0 (force voltage) and the voltage set when it is 1 (force current).
- R9: Reserved codes change no state, and their readback returns 0. Reserved codes are: DAC select 6 or 7, range 6 or 7, clamp ranges 1 to 4, mode 00, offset with mode other than 11, and a zero mask.
- R10: A write with several mask bits set updates the register in every addressed channel in the same cycle. A readback with several mask bits set returns the lowest-numbered channel's value.
- R11: After reset, every X1 is 0, every M is 0xFFFF, every C is 0x8000, every X2 is 0 and the offset word is 0. Hence X2 equals X1 until coefficients are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Write strobe |
| wr_mask_i | input | NCH | Channel mask for writes |
| wr_dac_i | input | 3 | DAC select for writes |
| wr_rng_i | input | 3 | Range select for writes |
| wr_mode_i | input | 2 | Register select for writes |
| wr_data_i | input | CW | Write data |
| rd_mask_i | input | NCH | Channel mask for readback |
| rd_dac_i | input | 3 | DAC select for readback |
| rd_rng_i | input | 3 | Range select for readback |
| rd_mode_i | input | 2 | Register select for readback |
| rd_data_o | output | CW | Readback data |
| frange_i | input | 3*NCH | Active force range per channel |
| fmode_i | input | NCH | Force mode per channel (1 = force current) |
| force_x2_o | output | CW*NCH | Active force DAC code per channel |
| cmplo_x2_o | output | CW*NCH | Active comparator-low code per channel |
| cmphi_x2_o | output | CW*NCH | Active comparator-high code per channel |
| clamplo_x2_o | output | CW*NCH | Active clamp-low code per channel |
| clamphi_x2_o | output | CW*NCH | Active clamp-high code per channel |
| ofs_code_o | output | CW | Shared offset DAC code |
| x2_done_o | output | 1 | Pulse when a new X2 is stored |

## Verification
The bench builds the block with NCH = 4 and CW = 16. Four channels let it write through many mask patterns and check that readback picks the lowest-numbered channel whenever several channel bits are set. Full 16-bit codes let directed and random X1, M and C values drive the corrected result past both saturation limits. Random force ranges, including the values 6 and 7, and random force modes are mixed in so that every set of every DAC reaches the outputs.

// File: rtl/calbank_pkg.sv
package calbank_pkg;

    // Sets per channel: three DACs with six ranges each, two clamps with two sets each.
    localparam int NRNG  = 6;
    localparam int NFULL = 3;
    localparam int NCLMP = 2;
    localparam int NSET  = NFULL * NRNG + NCLMP * 2;
    localparam int SETW  = $clog2(NSET);
    localparam int NDAC  = NFULL + NCLMP;

    localparam logic [2:0] DAC_CLAMP_LO = 3'd3;
    localparam logic [2:0] DAC_CLAMP_HI = 3'd4;
    localparam logic [2:0] DAC_OFFSET   = 3'd5;
    localparam logic [2:0] RNG_VOLT     = 3'd5;

    typedef enum logic [1:0] {
        MD_NONE = 2'b00,
        MD_M    = 2'b01,
        MD_C    = 2'b10,
        MD_X1   = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_SET,
        TGT_OFS
    } tgt_e;

    typedef struct packed {
        tgt_e            tgt;
        mode_e           mode;
        logic [SETW-1:0] set;
    } dec_t;

    function automatic logic [SETW-1:0] full_set(input logic [2:0] dac, input logic [2:0] rng);
        return SETW'(int'(dac) * NRNG + int'(rng));
    endfunction

    function automatic logic [SETW-1:0] clamp_set(input logic [2:0] dac, input logic volt);
        return SETW'(NFULL * NRNG + (int'(dac) - int'(DAC_CLAMP_LO)) * 2 + int'(volt));
    endfunction

endpackage

// File: rtl/calbank_decode.sv
module calbank_decode
    import calbank_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0] mask_i,
    input  logic [2:0]     dac_i,
    input  logic [2:0]     rng_i,
    input  logic [1:0]     mode_i,
    output dec_t           dec_o
);

    always_comb begin
        dec_o.tgt  = TGT_NONE;
        dec_o.mode = mode_e'(mode_i);
        dec_o.set  = '0;
        if ((mask_i != '0) && (mode_i != MD_NONE)) begin
            if ((dac_i < DAC_CLAMP_LO) && (rng_i <= RNG_VOLT)) begin
                dec_o.tgt = TGT_SET;
                dec_o.set = full_set(dac_i, rng_i);
            end else if (((dac_i == DAC_CLAMP_LO) || (dac_i == DAC_CLAMP_HI)) &&
                         ((rng_i == 3'd0) || (rng_i == RNG_VOLT))) begin
                dec_o.tgt = TGT_SET;
                dec_o.set = clamp_set(dac_i, rng_i == RNG_VOLT);
            end else if ((dac_i == DAC_OFFSET) && (mode_i == MD_X1)) begin
                dec_o.tgt = TGT_OFS;
            end
        end
    end

endmodule

// File: rtl/calbank_x2_pipe.sv
module calbank_x2_pipe
    import calbank_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            start_i,
    input  logic [CW-1:0]   x1_i,
    input  logic [CW-1:0]   m_i,
    input  logic [CW-1:0]   c_i,
    input  logic [SETW-1:0] set_i,
    output logic            res_vld_o,
    output logic [SETW-1:0] res_set_o,
    output logic [CW-1:0]   res_code_o
);

    localparam int PW = 2 * CW;
    localparam logic [CW+1:0] HALF = (CW+2)'(1) << (CW - 1);
    localparam logic [CW+1:0] TOP  = (CW+2)'((1 << CW) - 1);

    logic [CW:0]     m_p1;
    logic [PW-1:0]   prod;
    logic [CW-1:0]   prod_hi;

    logic            s1_vld;
    logic [CW-1:0]   s1_hi;
    logic [CW-1:0]   s1_c;
    logic [SETW-1:0] s1_set;

    logic [CW+1:0]   sum;
    logic [CW+1:0]   diff;

    // Stage 1: gain product, keep the upper half
    assign m_p1    = {1'b0, m_i} + (CW+1)'(1);
    assign prod    = PW'(x1_i) * PW'(m_p1);
    assign prod_hi = CW'(prod >> CW);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s1_vld <= 1'b0;
            s1_hi  <= '0;
            s1_c   <= '0;
            s1_set <= '0;
        end else begin
            s1_vld <= start_i;
            if (start_i) begin
                s1_hi  <= prod_hi;
                s1_c   <= c_i;
                s1_set <= set_i;
            end
        end
    end

    // Stage 2: offset add with saturation at both ends
    assign sum  = {2'b00, s1_hi} + {2'b00, s1_c};
    assign diff = sum - HALF;

    always_comb begin
        if (sum < HALF) begin
            res_code_o = '0;
        end else if (diff > TOP) begin
            res_code_o = '1;
        end else begin
            res_code_o = diff[CW-1:0];
        end
    end

    assign res_vld_o = s1_vld;
    assign res_set_o = s1_set;

endmodule

// File: rtl/calbank_chan.sv
module calbank_chan
    import calbank_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  logic                     wr_sel_i,
    input  dec_t                     wr_dec_i,
    input  logic [CW-1:0]            wr_data_i,
    input  dec_t                     rd_dec_i,
    output logic [CW-1:0]            rd_data_o,
    input  logic [2:0]               frange_i,
    input  logic                     fmode_i,
    output logic [NDAC-1:0][CW-1:0]  act_o,
    output logic                     res_vld_o
);

    localparam logic [CW-1:0] M_RST = '1;
    localparam logic [CW-1:0] C_RST = CW'(1) << (CW - 1);

    logic [CW-1:0] x1_q [NSET];
    logic [CW-1:0] m_q  [NSET];
    logic [CW-1:0] c_q  [NSET];
    logic [CW-1:0] x2_q [NSET];

    logic            start;
    logic [SETW-1:0] res_set;
    logic [CW-1:0]   res_code;
    logic [2:0]      eff_rng;

    assign start = wr_sel_i && (wr_dec_i.mode == MD_X1);

    calbank_x2_pipe #(.CW(CW)) u_pipe (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .start_i    (start),
        .x1_i       (wr_data_i),
        .m_i        (m_q[wr_dec_i.set]),
        .c_i        (c_q[wr_dec_i.set]),
        .set_i      (wr_dec_i.set),
        .res_vld_o  (res_vld_o),
        .res_set_o  (res_set),
        .res_code_o (res_code)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int s = 0; s < NSET; s++) begin
                x1_q[s] <= '0;
                m_q[s]  <= M_RST;
                c_q[s]  <= C_RST;
                x2_q[s] <= '0;
            end
        end else begin
            if (wr_sel_i) begin
                unique case (wr_dec_i.mode)
                    MD_M:    m_q[wr_dec_i.set]  <= wr_data_i;
                    MD_C:    c_q[wr_dec_i.set]  <= wr_data_i;
                    MD_X1:   x1_q[wr_dec_i.set] <= wr_data_i;
                    default: ;
                endcase
            end
            if (res_vld_o) begin
                x2_q[res_set] <= res_code;
            end
        end
    end

    // Readback of the addressed register
    always_comb begin
        rd_data_o = '0;
        if (rd_dec_i.tgt == TGT_SET) begin
            unique case (rd_dec_i.mode)
                MD_M:    rd_data_o = m_q[rd_dec_i.set];
                MD_C:    rd_data_o = c_q[rd_dec_i.set];
                MD_X1:   rd_data_o = x1_q[rd_dec_i.set];
                default: rd_data_o = '0;
            endcase
        end
    end

    // Active code selection
    assign eff_rng = (frange_i >= RNG_VOLT) ? RNG_VOLT : frange_i;

    for (genvar d = 0; d < NDAC; d++) begin : g_act
        if (d < NFULL) begin : g_full
            assign act_o[d] = x2_q[full_set(3'(d), eff_rng)];
        end else begin : g_clamp
            assign act_o[d] = x2_q[clamp_set(3'(d), fmode_i)];
        end
    end

endmodule

// File: rtl/calbank_top.sv
module calbank_top
    import calbank_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [NCH-1:0]    wr_mask_i,
    input  logic [2:0]        wr_dac_i,
    input  logic [2:0]        wr_rng_i,
    input  logic [1:0]        wr_mode_i,
    input  logic [CW-1:0]     wr_data_i,
    input  logic [NCH-1:0]    rd_mask_i,
    input  logic [2:0]        rd_dac_i,
    input  logic [2:0]        rd_rng_i,
    input  logic [1:0]        rd_mode_i,
    output logic [CW-1:0]     rd_data_o,
    input  logic [3*NCH-1:0]  frange_i,
    input  logic [NCH-1:0]    fmode_i,
    output logic [CW*NCH-1:0] force_x2_o,
    output logic [CW*NCH-1:0] cmplo_x2_o,
    output logic [CW*NCH-1:0] cmphi_x2_o,
    output logic [CW*NCH-1:0] clamplo_x2_o,
    output logic [CW*NCH-1:0] clamphi_x2_o,
    output logic [CW-1:0]     ofs_code_o,
    output logic              x2_done_o
);

    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

    dec_t           wr_dec;
    dec_t           rd_dec;
    logic [NCH-1:0] res_vld;
    logic [CW-1:0]  chan_rd [NCH];
    logic [CW-1:0]  ofs_q;
    logic           done_q;
    logic [CHW-1:0] pick;

    calbank_decode #(.NCH(NCH)) u_wr_dec (
        .mask_i (wr_mask_i),
        .dac_i  (wr_dac_i),
        .rng_i  (wr_rng_i),
        .mode_i (wr_mode_i),
        .dec_o  (wr_dec)
    );

    calbank_decode #(.NCH(NCH)) u_rd_dec (
        .mask_i (rd_mask_i),
        .dac_i  (rd_dac_i),
        .rng_i  (rd_rng_i),
        .mode_i (rd_mode_i),
        .dec_o  (rd_dec)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [NDAC-1:0][CW-1:0] act;
        logic                    wr_sel;

        assign wr_sel = wr_en_i && wr_mask_i[g] && (wr_dec.tgt == TGT_SET);

        calbank_chan #(.CW(CW)) u_chan (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .wr_sel_i  (wr_sel),
            .wr_dec_i  (wr_dec),
            .wr_data_i (wr_data_i),
            .rd_dec_i  (rd_dec),
            .rd_data_o (chan_rd[g]),
            .frange_i  (frange_i[3*g +: 3]),
            .fmode_i   (fmode_i[g]),
            .act_o     (act),
            .res_vld_o (res_vld[g])
        );

        assign force_x2_o[CW*g +: CW]   = act[0];
        assign cmplo_x2_o[CW*g +: CW]   = act[1];
        assign cmphi_x2_o[CW*g +: CW]   = act[2];
        assign clamplo_x2_o[CW*g +: CW] = act[3];
        assign clamphi_x2_o[CW*g +: CW] = act[4];
    end

    // Shared offset word and the completion strobe
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ofs_q  <= '0;
            done_q <= 1'b0;
        end else begin
            if (wr_en_i && (wr_dec.tgt == TGT_OFS)) begin
                ofs_q <= wr_data_i;
            end
            done_q <= |res_vld;
        end
    end

    // Lowest addressed channel wins on readback
    always_comb begin
        pick = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (rd_mask_i[i]) begin
                pick = CHW'(i);
            end
        end
    end

    always_comb begin
        unique case (rd_dec.tgt)
            TGT_SET: rd_data_o = chan_rd[pick];
            TGT_OFS: rd_data_o = ofs_q;
            default: rd_data_o = '0;
        endcase
    end

    assign ofs_code_o = ofs_q;
    assign x2_done_o  = done_q;

endmodule

// File: rtl/calbank_chk.sv
module calbank_chk #(
    parameter int NCH = 4,
    parameter int CW  = 16
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              wr_en_i,
    input logic [NCH-1:0]    wr_mask_i,
    input logic [2:0]        wr_dac_i,
    input logic [2:0]        wr_rng_i,
    input logic [1:0]        wr_mode_i,
    input logic [NCH-1:0]    rd_mask_i,
    input logic [2:0]        rd_dac_i,
    input logic [1:0]        rd_mode_i,
    input logic [CW-1:0]     rd_data_o,
    input logic [3*NCH-1:0]  frange_i,
    input logic [NCH-1:0]    fmode_i,
    input logic [CW*NCH-1:0] force_x2_o,
    input logic [CW*NCH-1:0] cmplo_x2_o,
    input logic [CW*NCH-1:0] cmphi_x2_o,
    input logic [CW*NCH-1:0] clamplo_x2_o,
    input logic [CW*NCH-1:0] clamphi_x2_o,
    input logic [CW-1:0]     ofs_code_o,
    input logic              x2_done_o
);

    logic wr_x1;
    logic wr_ofs;

    assign wr_x1 = wr_en_i && (wr_mask_i != '0) && (wr_mode_i == 2'b11) &&
                   (((wr_dac_i <= 3'd2) && (wr_rng_i <= 3'd5)) ||
                    (((wr_dac_i == 3'd3) || (wr_dac_i == 3'd4)) &&
                     ((wr_rng_i == 3'd0) || (wr_rng_i == 3'd5))));
    assign wr_ofs = wr_en_i && (wr_mask_i != '0) && (wr_dac_i == 3'd5) && (wr_mode_i == 2'b11);

    // R6: an accepted X1 write produces the completion strobe two cycles later
    assert_done_latency_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_x1 |=> ##1 x2_done_o);

    // R5: without a completion strobe and with steady range/mode inputs, no code output moves
    assert_hold_without_x1_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!x2_done_o && $stable(frange_i) && $stable(fmode_i)) |->
        ($stable(force_x2_o) && $stable(cmplo_x2_o) && $stable(cmphi_x2_o) &&
         $stable(clamplo_x2_o) && $stable(clamphi_x2_o)));

    // R7: the offset word changes only after an offset write
    assert_ofs_only_on_write_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(wr_ofs) |-> $stable(ofs_code_o));

    // R9: reserved readback codes return zero
    assert_rd_reserved_zero_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        ((rd_mode_i == 2'b00) || (rd_mask_i == '0) || (rd_dac_i > 3'd5)) |-> (rd_data_o == '0));

endmodule

bind calbank_top calbank_chk #(.NCH(NCH), .CW(CW)) u_calbank_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .wr_en_i      (wr_en_i),
    .wr_mask_i    (wr_mask_i),
    .wr_dac_i     (wr_dac_i),
    .wr_rng_i     (wr_rng_i),
    .wr_mode_i    (wr_mode_i),
    .rd_mask_i    (rd_mask_i),
    .rd_dac_i     (rd_dac_i),
    .rd_mode_i    (rd_mode_i),
    .rd_data_o    (rd_data_o),
    .frange_i     (frange_i),
    .fmode_i      (fmode_i),
    .force_x2_o   (force_x2_o),
    .cmplo_x2_o   (cmplo_x2_o),
    .cmphi_x2_o   (cmphi_x2_o),
    .clamplo_x2_o (clamplo_x2_o),
    .clamphi_x2_o (clamphi_x2_o),
    .ofs_code_o   (ofs_code_o),
    .x2_done_o    (x2_done_o)
);

// File: tb/test_calbank_top.sv
`timescale 1ns/1ps
module test_calbank_top;

    localparam int NCH  = 4;
    localparam int CW   = 16;
    localparam int NS   = 22;

    logic              clk = 1'b0;
    logic              rst_i;
    logic              wr_en_i;
    logic [NCH-1:0]    wr_mask_i;
    logic [2:0]        wr_dac_i;
    logic [2:0]        wr_rng_i;
    logic [1:0]        wr_mode_i;
    logic [CW-1:0]     wr_data_i;
    logic [NCH-1:0]    rd_mask_i;
    logic [2:0]        rd_dac_i;
    logic [2:0]        rd_rng_i;
    logic [1:0]        rd_mode_i;
    logic [CW-1:0]     rd_data_o;
    logic [3*NCH-1:0]  frange_i;
    logic [NCH-1:0]    fmode_i;
    logic [CW*NCH-1:0] force_x2_o, cmplo_x2_o, cmphi_x2_o, clamplo_x2_o, clamphi_x2_o;
    logic [CW-1:0]     ofs_code_o;
    logic              x2_done_o;

    always #2 clk = ~clk;

    calbank_top #(.NCH(NCH), .CW(CW)) i_calbank_top (
        .clk_i(clk), .rst_i(rst_i), .wr_en_i(wr_en_i), .wr_mask_i(wr_mask_i),
        .wr_dac_i(wr_dac_i), .wr_rng_i(wr_rng_i), .wr_mode_i(wr_mode_i), .wr_data_i(wr_data_i),
        .rd_mask_i(rd_mask_i), .rd_dac_i(rd_dac_i), .rd_rng_i(rd_rng_i), .rd_mode_i(rd_mode_i),
        .rd_data_o(rd_data_o), .frange_i(frange_i), .fmode_i(fmode_i),
        .force_x2_o(force_x2_o), .cmplo_x2_o(cmplo_x2_o), .cmphi_x2_o(cmphi_x2_o),
        .clamplo_x2_o(clamplo_x2_o), .clamphi_x2_o(clamphi_x2_o),
        .ofs_code_o(ofs_code_o), .x2_done_o(x2_done_o)
    );

    int total = 0;
    int bad   = 0;
    bit run_over = 1'b0;

    logic [CW-1:0] mx1 [NCH][NS];
    logic [CW-1:0] mm  [NCH][NS];
    logic [CW-1:0] mc  [NCH][NS];
    logic [CW-1:0] mx2 [NCH][NS];
    logic [CW-1:0] mofs;

    // Set index per R1/R2 encoding, -1 when reserved
    function automatic int set_idx(int dac, int rng);
        if (dac <= 2 && rng <= 5) return dac * 6 + rng;
        if ((dac == 3 || dac == 4) && (rng == 0 || rng == 5)) return 18 + (dac - 3) * 2 + (rng == 5 ? 1 : 0);
        return -1;
    endfunction

    // R4 corrected code
    function automatic logic [CW-1:0] calc(logic [CW-1:0] x1, logic [CW-1:0] m, logic [CW-1:0] c);
        longint v;
        v = ((longint'(x1) * (longint'(m) + 1)) >>> 16) + longint'(c) - 32768;
        if (v < 0) return '0;
        if (v > 65535) return '1;
        return CW'(v);
    endfunction

    function automatic logic [CW-1:0] act_out(int ch, int d);
        case (d)
            0: return force_x2_o[ch*CW +: CW];
            1: return cmplo_x2_o[ch*CW +: CW];
            2: return cmphi_x2_o[ch*CW +: CW];
            3: return clamplo_x2_o[ch*CW +: CW];
            default: return clamphi_x2_o[ch*CW +: CW];
        endcase
    endfunction

    task automatic check(string req, logic [CW-1:0] act, logic [CW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(logic [NCH-1:0] mask, int dac, int rng, int mode, logic [CW-1:0] data);
        int s;
        @(negedge clk);
        wr_mask_i = mask; wr_dac_i = 3'(dac); wr_rng_i = 3'(rng);
        wr_mode_i = 2'(mode); wr_data_i = data; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
        if (mask != 0 && mode != 0) begin
            s = set_idx(dac, rng);
            if (s >= 0) begin
                for (int ch = 0; ch < NCH; ch++) begin
                    if (mask[ch]) begin
                        if (mode == 1) mm[ch][s] = data;
                        else if (mode == 2) mc[ch][s] = data;
                        else begin
                            mx1[ch][s] = data;
                            mx2[ch][s] = calc(data, mm[ch][s], mc[ch][s]);
                        end
                    end
                end
            end else if (dac == 5 && mode == 3) begin
                mofs = data;
            end
        end
    endtask

    function automatic bit is_x1(logic [NCH-1:0] mask, int dac, int rng, int mode);
        return (mask != 0) && (mode == 3) && (set_idx(dac, rng) >= 0);
    endfunction

    task automatic check_outs(string req);
        int s;
        int fr;
        for (int ch = 0; ch < NCH; ch++) begin
            fr = int'(frange_i[3*ch +: 3]);
            if (fr > 5) fr = 5;
            for (int d = 0; d < 5; d++) begin
                if (d < 3) s = set_idx(d, fr);
                else s = set_idx(d, fmode_i[ch] ? 5 : 0);
                check(req, act_out(ch, d), mx2[ch][s]);
            end
        end
        check(req, ofs_code_o, mofs);
    endtask

    task automatic check_rd(string req, logic [NCH-1:0] mask, int dac, int rng, int mode);
        logic [CW-1:0] exp;
        int s;
        int lo;
        rd_mask_i = mask; rd_dac_i = 3'(dac); rd_rng_i = 3'(rng); rd_mode_i = 2'(mode);
        #1;
        exp = '0;
        lo = 0;
        for (int ch = NCH - 1; ch >= 0; ch--) if (mask[ch]) lo = ch;
        s = set_idx(dac, rng);
        if (mask != 0 && mode != 0) begin
            if (s >= 0) begin
                if (mode == 1) exp = mm[lo][s];
                else if (mode == 2) exp = mc[lo][s];
                else exp = mx1[lo][s];
            end else if (dac == 5 && mode == 3) begin
                exp = mofs;
            end
        end
        check(req, rd_data_o, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!run_over) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [NCH-1:0] mk;
        int dc, rg, md;
        logic [CW-1:0] dt;
        void'($urandom(32'd20240611));
        for (int ch = 0; ch < NCH; ch++)
            for (int s = 0; s < NS; s++) begin
                mx1[ch][s] = '0; mm[ch][s] = 16'hFFFF; mc[ch][s] = 16'h8000; mx2[ch][s] = '0;
            end
        mofs = '0;
        rst_i = 1'b1; wr_en_i = 1'b0; wr_mask_i = '0; wr_dac_i = '0; wr_rng_i = '0;
        wr_mode_i = '0; wr_data_i = '0; rd_mask_i = '0; rd_dac_i = '0; rd_rng_i = '0;
        rd_mode_i = '0; frange_i = '0; fmode_i = '0;
        repeat (3) @(negedge clk);
        rst_i = 1'b0;

        // R11 reset state
        check_rd("R11 reset M", 4'b0001, 0, 0, 1);
        check_rd("R11 reset C", 4'b1000, 4, 5, 2);
        check_rd("R11 reset X1", 4'b0100, 2, 3, 3);
        check("R11 reset done", 16'(x2_done_o), 16'h0);
        check_outs("R11 reset outputs");

        // R6 latency and R4 identity with default coefficients
        do_write(4'b0001, 0, 0, 3, 16'h1234);
        check("R6 done low at k+1", 16'(x2_done_o), 16'h0);
        check("R6 X2 not yet at k+1", act_out(0, 0), 16'h0000);
        @(negedge clk);
        check("R6 done high at k+2", 16'(x2_done_o), 16'h1);
        check("R4 identity X2", act_out(0, 0), 16'h1234);
        @(negedge clk);
        check("R6 done single pulse", 16'(x2_done_o), 16'h0);

        // R5 M write leaves X2 alone, next X1 write uses new M
        do_write(4'b0001, 0, 0, 1, 16'h7FFF);
        @(negedge clk);
        check("R5 M write no X2 change", act_out(0, 0), 16'h1234);
        check("R5 no done on M write", 16'(x2_done_o), 16'h0);
        do_write(4'b0001, 0, 0, 2, 16'h9000);
        @(negedge clk);
        check("R5 C write no X2 change", act_out(0, 0), 16'h1234);
        do_write(4'b0001, 0, 0, 3, 16'h1234);
        @(negedge clk);
        check("R5 recompute after X1", act_out(0, 0), 16'h191A);

        // R4 saturation high and low, R8 voltage range via codes 5 and 7
        frange_i[3 +: 3] = 3'd7;
        do_write(4'b0010, 1, 5, 2, 16'hFFFF);
        do_write(4'b0010, 1, 5, 3, 16'hFFFF);
        @(negedge clk);
        check("R4 saturate high", act_out(1, 1), 16'hFFFF);
        do_write(4'b0010, 2, 5, 2, 16'h0000);
        do_write(4'b0010, 2, 5, 3, 16'h0010);
        @(negedge clk);
        check("R4 saturate low", act_out(1, 2), 16'h0000);
        check_outs("R8 range 7 selects voltage set");

        // R2 and R8 clamp set selection from the force mode
        do_write(4'b0100, 3, 0, 3, 16'h1111);
        do_write(4'b0100, 3, 5, 3, 16'h2222);
        @(negedge clk);
        fmode_i[2] = 1'b0; #1;
        check("R8 force voltage uses current clamp set", act_out(2, 3), 16'h1111);
        fmode_i[2] = 1'b1; #1;
        check("R8 force current uses voltage clamp set", act_out(2, 3), 16'h2222);

        // R9 reserved codes
        do_write(4'b0100, 3, 2, 3, 16'hDEAD);
        do_write(4'b1111, 6, 0, 3, 16'hDEAD);
        do_write(4'b1111, 0, 6, 3, 16'hDEAD);
        do_write(4'b1111, 0, 0, 0, 16'hDEAD);
        do_write(4'b0000, 0, 0, 3, 16'hDEAD);
        do_write(4'b0001, 5, 0, 1, 16'hDEAD);
        @(negedge clk);
        check("R9 no done on reserved", 16'(x2_done_o), 16'h0);
        check_outs("R9 reserved writes ignored");
        check_rd("R9 reserved readback clamp range", 4'b0100, 3, 2, 3);
        check_rd("R9 reserved readback mode 00", 4'b0001, 0, 0, 0);

        // R7 offset word, range ignored
        do_write(4'b1000, 5, 7, 3, 16'h4321);
        @(negedge clk);
        check("R7 offset write", ofs_code_o, 16'h4321);
        check_rd("R7 offset readback", 4'b0010, 5, 0, 3);

        // R10 multi-channel write and lowest-channel readback
        do_write(4'b1111, 2, 3, 2, 16'hAAAA);
        do_write(4'b0010, 2, 3, 2, 16'h5555);
        check_rd("R10 lowest channel ch1", 4'b1110, 2, 3, 2);
        check_rd("R10 lowest channel ch0", 4'b1101, 2, 3, 2);
        check_rd("R10 ch3 updated", 4'b1000, 2, 3, 2);

        // Random mix covering R1 R3 R6 R9
        for (int i = 0; i < 400; i++) begin
            mk = NCH'($urandom);
            dc = int'($urandom % 8);
            rg = ($urandom % 3 == 0) ? 0 : int'($urandom % 8);
            md = int'($urandom % 4);
            dt = CW'($urandom);
            if (i % 5 == 0) begin
                frange_i = (3*NCH)'($urandom);
                fmode_i  = NCH'($urandom);
            end
            do_write(mk, dc, rg, md, dt);
            @(negedge clk);
            check("R6 random done", 16'(x2_done_o), 16'(is_x1(mk, dc, rg, md)));
            check_outs("R1 random outputs");
            check_rd("R3 random readback", mk, dc, rg, md);
        end

        run_over = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule